// File: doc/BRIEF.md
# Memory-Mapped Event Bridge Between Bus and Hardware Machines

This block joins a small processor bus to a set of hardware state machines and carries event/value pairs in both directions. The bus has an address, a write-data word, a write enable and an output enable. An address decoder finds the block's registers, and a read multiplexer returns them on a read-data word. The block drives that word only while a read of its own window is under way.

Toward hardware, each outgoing event has a value register. Software loads the value first. It then sets the event's bit in a fire register, and that gives the hardware one strobe cycle with the value held steady on the value bus. Each outgoing slot is a two-state machine: `OS_IDLE` goes to `OS_FIRE` on transition *fire* (a fire bit is written), and `OS_FIRE` goes back to `OS_IDLE` on transition *expire*, one cycle later in every case.

From hardware, each incoming event is a strobe with a value. The value is latched and a pending flag is set. Each incoming slot is a two-state machine:
- `IS_CLEAR` goes to `IS_PENDING` on *arrive* (hardware strobe).
- `IS_PENDING` stays where it is on *refresh* (another strobe, new value taken).
- `IS_PENDING` goes to `IS_CLEAR` on *acknowledge* (acknowledge bit without a strobe).

A mode register sets each incoming event to polled, where software reads the status word, or to interrupt, where a pending flag raises the interrupt request.

Top module: `evb_bridge`

Register offsets within the window are formed as {group[1:0], index[3:0]}:
- group 0 holds the outgoing values at index i.
- group 1 is the fire register.
- group 2 holds status at index 0, acknowledge at index 1 and mode at index 2.
- group 3 holds the incoming latched values at index j.

The window is hit when address bits [7:6] equal 2'b01, so with the defaults it spans 0x40 to 0x7F. With the defaults there are 2 outgoing events, 4 incoming events and 16-bit values.

## Requirements
- R1: After reset, every strobe, value, pending flag and mode bit is zero, the interrupt request is low and the read-data word is not driven.
- R2: A write to outgoing value register i (0x40+i) stores the full data word, shows it on value lane i of `sw_val_o`, and reads back from the same address. A value write alone raises no strobe.
- R3: Writing the fire register (0x50) with bit i set gives `sw_stb_o[i]` one single high cycle, in the cycle after the write. Zero bits have no effect. A fire write made while that strobe is high is ignored.
- R4: A high `hw_stb_i[j]` latches lane j of `hw_val_i` into incoming value register j (0x70+j) and sets status bit j (0x60), both from the next cycle on. A strobe while the event is already pending overwrites the value.
- R5: Reading the status register does not change any pending flag.
- R6: Writing the acknowledge register (0x61) with bit j set clears pending flag j. Bits written as zero, and acknowledges of a flag that is already clear, have no effect, and the latched value is kept.
- R7: When a hardware strobe and an acknowledge of the same event fall in the same cycle, the event stays pending and holds the new value.
- R8: The mode register (0x62) marks an event as interrupt-driven with bit j = 1, or polled with bit j = 0. `irq_o` is high exactly when some pending event is in interrupt mode.
- R9: `bus_rdata_drive` is high only while `bus_oe` is high and address bits [7:6] are 2'b01. Otherwise `bus_rdata` is zero. Writes outside the window change nothing.
- R10: Reads of offsets with no register behind them, including indices beyond the event counts and the fire and acknowledge registers, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_oe | input | 1 | Output enable for reads |
| bus_rdata | output | 16 | Read data, zero when not driven |
| bus_rdata_drive | output | 1 | High while the block owns the read data |
| sw_val_o | output | 32 | Outgoing event values, lane i at bits [16i+15:16i] |
| sw_stb_o | output | 2 | Outgoing event strobes |
| hw_stb_i | input | 4 | Incoming event strobes |
| hw_val_i | input | 64 | Incoming event values, lane j at bits [16j+15:16j] |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- each outgoing strobe lasts one cycle and follows a fire request;
- a hardware strobe always leaves its slot pending with the sampled value;
- a lone acknowledge clears its flag, and values and flags hold when nothing touches them;
- the read word stays quiet whenever output enable is low.

Only the bench's scenarios can show the register map as software sees it:
- read-back through the decoder;
- zero on unmapped offsets;
- writes that miss the window being dropped;
- a repeated fire during a strobe being lost;
- the strobe winning a same-cycle collision with an acknowledge;
- the interrupt following both changes of mode and acknowledges.

// File: rtl/evb_pkg.sv
package evb_pkg;

    // Offset inside the block window: {group, index}
    localparam int unsigned OFF_W = 6;
    localparam int unsigned IDX_W = 4;

    typedef enum logic [1:0] {
        GRP_OVAL = 2'd0,
        GRP_FIRE = 2'd1,
        GRP_CTRL = 2'd2,
        GRP_IVAL = 2'd3
    } grp_e;

    localparam logic [IDX_W-1:0] CTRL_STATUS = 4'd0;
    localparam logic [IDX_W-1:0] CTRL_ACK    = 4'd1;
    localparam logic [IDX_W-1:0] CTRL_MODE   = 4'd2;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_FIRE = 1'b1
    } out_state_e;

    typedef enum logic {
        IS_CLEAR   = 1'b0,
        IS_PENDING = 1'b1
    } in_state_e;

endpackage

// File: rtl/evb_decode.sv
module evb_decode
    import evb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned N_OUT    = 2,
    parameter int unsigned N_IN     = 4,
    parameter int unsigned VAL_W    = 16,
    parameter int unsigned BLK_BASE = 1
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   we,
    input  logic                   oe,
    input  logic [N_OUT*VAL_W-1:0] oval,
    input  logic [N_IN*VAL_W-1:0]  ival,
    input  logic [N_IN-1:0]        pend,
    input  logic [N_IN-1:0]        mode,
    output logic [N_OUT-1:0]       wr_oval,
    output logic                   wr_fire,
    output logic                   wr_ack,
    output logic                   wr_mode,
    output logic [DATA_W-1:0]      rdata,
    output logic                   drive
);

    localparam int unsigned HI_W = ADDR_W - OFF_W;
    localparam logic [HI_W-1:0] BASE_HI = HI_W'(BLK_BASE);

    logic             hit;
    grp_e             grp;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rmux;

    always_comb begin
        hit = (addr[ADDR_W-1:OFF_W] == BASE_HI);
        grp = grp_e'(addr[OFF_W-1:IDX_W]);
        idx = addr[IDX_W-1:0];
    end

    // Write decoder
    always_comb begin
        wr_oval = '0;
        wr_fire = 1'b0;
        wr_ack  = 1'b0;
        wr_mode = 1'b0;
        if (hit && we) begin
            unique case (grp)
                GRP_OVAL: begin
                    for (int i = 0; i < int'(N_OUT); i++) begin
                        if (idx == IDX_W'(i)) wr_oval[i] = 1'b1;
                    end
                end
                GRP_FIRE: wr_fire = 1'b1;
                GRP_CTRL: begin
                    wr_ack  = (idx == CTRL_ACK);
                    wr_mode = (idx == CTRL_MODE);
                end
                GRP_IVAL: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        rmux = '0;
        unique case (grp)
            GRP_OVAL: begin
                for (int i = 0; i < int'(N_OUT); i++) begin
                    if (idx == IDX_W'(i)) rmux = DATA_W'(oval[i*VAL_W +: VAL_W]);
                end
            end
            GRP_FIRE: rmux = '0;
            GRP_CTRL: begin
                if (idx == CTRL_STATUS)    rmux = DATA_W'(pend);
                else if (idx == CTRL_MODE) rmux = DATA_W'(mode);
            end
            GRP_IVAL: begin
                for (int j = 0; j < int'(N_IN); j++) begin
                    if (idx == IDX_W'(j)) rmux = DATA_W'(ival[j*VAL_W +: VAL_W]);
                end
            end
        endcase
    end

    always_comb begin
        drive = hit && oe;
        rdata = drive ? rmux : '0;
    end

endmodule

// File: rtl/evb_out_slot.sv
module evb_out_slot
    import evb_pkg::*;
#(
    parameter int unsigned VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic [VAL_W-1:0] wdata,
    input  logic             fire_req,
    output logic [VAL_W-1:0] val_o,
    output logic             stb_o
);

    out_state_e state_q, state_d;
    logic [VAL_W-1:0] val_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: fire (IDLE->FIRE), expire (FIRE->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: if (fire_req) state_d = OS_FIRE;
            OS_FIRE: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (wr_val) val_q <= wdata;
    end

    // Outputs
    always_comb begin
        stb_o = (state_q == OS_FIRE);
        val_o = val_q;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o); // R3
    AST_FIRE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_req && !stb_o) |=> stb_o); // R3
    AST_OVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_val |=> $stable(val_o)); // R2

endmodule

// File: rtl/evb_in_slot.sv
module evb_in_slot
    import evb_pkg::*;
#(
    parameter int unsigned VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stb,
    input  logic [VAL_W-1:0] hw_val,
    input  logic             ack,
    output logic             pend_o,
    output logic [VAL_W-1:0] val_o
);

    in_state_e state_q, state_d;
    logic [VAL_W-1:0] val_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IS_CLEAR;
        else        state_q <= state_d;
    end

    // Transitions: arrive, refresh, acknowledge (strobe beats ack)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IS_CLEAR:   if (hw_stb) state_d = IS_PENDING;
            IS_PENDING: if (!hw_stb && ack) state_d = IS_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (hw_stb) val_q <= hw_val;
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == IS_PENDING);
        val_o  = val_q;
    end

    AST_STB_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stb |=> (pend_o && val_o == $past(hw_val))); // R4
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hw_stb) |=> !pend_o); // R6
    AST_IVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_stb |=> $stable(val_o)); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack) |=> pend_o); // R5

endmodule

// File: rtl/evb_bridge.sv
module evb_bridge
    import evb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned N_OUT    = 2,
    parameter int unsigned N_IN     = 4,
    parameter int unsigned VAL_W    = 16,
    parameter int unsigned BLK_BASE = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_we,
    input  logic                   bus_oe,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_rdata_drive,
    output logic [N_OUT*VAL_W-1:0] sw_val_o,
    output logic [N_OUT-1:0]       sw_stb_o,
    input  logic [N_IN-1:0]        hw_stb_i,
    input  logic [N_IN*VAL_W-1:0]  hw_val_i,
    output logic                   irq_o
);

    logic [N_OUT-1:0]      wr_oval;
    logic                  wr_fire, wr_ack, wr_mode;
    logic [N_IN-1:0]       pend;
    logic [N_IN*VAL_W-1:0] ival;
    logic [N_IN-1:0]       mode_q;

    evb_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_OUT(N_OUT),
        .N_IN(N_IN), .VAL_W(VAL_W), .BLK_BASE(BLK_BASE)
    ) decode_i (
        .addr(bus_addr), .we(bus_we), .oe(bus_oe),
        .oval(sw_val_o), .ival(ival), .pend(pend), .mode(mode_q),
        .wr_oval(wr_oval), .wr_fire(wr_fire), .wr_ack(wr_ack),
        .wr_mode(wr_mode), .rdata(bus_rdata), .drive(bus_rdata_drive)
    );

    for (genvar i = 0; i < int'(N_OUT); i++) begin : g_out
        evb_out_slot #(.VAL_W(VAL_W)) slot_i (
            .clk(clk), .rst_n(rst_n),
            .wr_val(wr_oval[i]),
            .wdata(VAL_W'(bus_wdata)),
            .fire_req(wr_fire && bus_wdata[i]),
            .val_o(sw_val_o[i*VAL_W +: VAL_W]),
            .stb_o(sw_stb_o[i])
        );
    end

    for (genvar j = 0; j < int'(N_IN); j++) begin : g_in
        evb_in_slot #(.VAL_W(VAL_W)) slot_i (
            .clk(clk), .rst_n(rst_n),
            .hw_stb(hw_stb_i[j]),
            .hw_val(hw_val_i[j*VAL_W +: VAL_W]),
            .ack(wr_ack && bus_wdata[j]),
            .pend_o(pend[j]),
            .val_o(ival[j*VAL_W +: VAL_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= bus_wdata[N_IN-1:0];
    end

    always_comb irq_o = |(pend & mode_q);

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (!bus_rdata_drive && bus_rdata == '0)); // R9
    AST_IRQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|mode_q)); // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|pend)); // R8

endmodule

// File: tb/evb_bridge_tb_top.sv
module evb_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_oe = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_rdata_drive;
    logic [31:0] sw_val_o;
    logic [1:0]  sw_stb_o;
    logic [3:0]  hw_stb_i = '0;
    logic [63:0] hw_val_i = '0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_oe(bus_oe), .bus_rdata(bus_rdata),
        .bus_rdata_drive(bus_rdata_drive), .sw_val_o(sw_val_o),
        .sw_stb_o(sw_stb_o), .hw_stb_i(hw_stb_i), .hw_val_i(hw_val_i),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a; bus_oe = 1'b1;
        #1;
        chk({tag, " drive"}, 32'(bus_rdata_drive), 32'd1);
        chk(tag, 32'(bus_rdata), 32'(exp));
        bus_oe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_in(input int j, input logic [15:0] v, input bit with_ack);
        hw_stb_i = 4'(1 << j);
        hw_val_i[j*16 +: 16] = v;
        if (with_ack) begin
            bus_addr = 8'h61; bus_wdata = 16'(1 << j); bus_we = 1'b1;
        end
        @(negedge clk);
        hw_stb_i = '0;
        bus_we = 1'b0;
    endtask

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam int NV = 12;
    // {op, addr, wdata, expected}
    localparam logic [41:0] VEC [NV] = '{
        {OP_RD, 8'h60, 16'h0000, 16'h0000},  // R1 status clear
        {OP_RD, 8'h62, 16'h0000, 16'h0000},  // R1 mode polled
        {OP_WR, 8'h40, 16'h12A5, 16'h0000},  // R2
        {OP_WR, 8'h41, 16'hC35A, 16'h0000},  // R2
        {OP_RD, 8'h40, 16'h0000, 16'h12A5},  // R2
        {OP_RD, 8'h41, 16'h0000, 16'hC35A},  // R2
        {OP_WR, 8'h80, 16'h00FF, 16'h0000},  // R9 write outside window
        {OP_RD, 8'h40, 16'h0000, 16'h12A5},  // R9 value unchanged
        {OP_WR, 8'h62, 16'h000A, 16'h0000},  // R8 events 1,3 interrupt
        {OP_RD, 8'h62, 16'h0000, 16'h000A},  // R8
        {OP_RD, 8'h4F, 16'h0000, 16'h0000},  // R10 index beyond outgoing count
        {OP_RD, 8'h7F, 16'h0000, 16'h0000}   // R10 index beyond incoming count
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 stb", 32'(sw_stb_o), 0);
        chk("R1 val", sw_val_o, 0);
        chk("R1 drive", 32'(bus_rdata_drive), 0);
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [41:0] e;
            e = VEC[k];
            if (e[41:40] == OP_WR) bus_write(e[39:32], e[31:16]);
            else bus_read(e[39:32], e[15:0], $sformatf("vector %0d (R1/R2/R8/R9/R10)", k));
        end

        chk("R2 value lanes", sw_val_o, 32'hC35A_12A5);
        chk("R2 no strobe from value write", 32'(sw_stb_o), 0);
        bus_read(8'h50, 16'h0, "R10 fire reads zero");
        bus_read(8'h61, 16'h0, "R10 ack reads zero");

        // R3 fire
        bus_write(8'h50, 16'h0001);
        chk("R3 strobe 0 high", 32'(sw_stb_o), 32'h1);
        chk("R3 value held", sw_val_o, 32'hC35A_12A5);
        @(negedge clk);
        chk("R3 strobe one cycle", 32'(sw_stb_o), 0);
        bus_write(8'h50, 16'h0003);
        chk("R3 both strobes", 32'(sw_stb_o), 32'h3);
        bus_write(8'h50, 16'h0003);
        chk("R3 fire during strobe ignored", 32'(sw_stb_o), 0);
        bus_write(8'h50, 16'h0000);
        chk("R3 zero bits no strobe", 32'(sw_stb_o), 0);

        // R4 latch
        pulse_in(2, 16'h3C3C, 1'b0);
        bus_read(8'h60, 16'h0004, "R4 status bit 2");
        bus_read(8'h72, 16'h3C3C, "R4 value 2");
        pulse_in(2, 16'h7777, 1'b0);
        bus_read(8'h72, 16'h7777, "R4 overwrite while pending");
        bus_read(8'h60, 16'h0004, "R5 status read keeps flag");

        // R6 acknowledge
        bus_write(8'h61, 16'h0001);
        bus_read(8'h60, 16'h0004, "R6 ack of clear flag no effect");
        bus_write(8'h61, 16'h0004);
        bus_read(8'h60, 16'h0000, "R6 ack clears");
        bus_read(8'h72, 16'h7777, "R6 value kept");
        bus_write(8'h61, 16'h0004);
        bus_read(8'h60, 16'h0000, "R6 repeated ack");

        // R7 collision
        pulse_in(0, 16'h1111, 1'b0);
        pulse_in(0, 16'h9999, 1'b1);
        bus_read(8'h60, 16'h0001, "R7 strobe wins");
        bus_read(8'h70, 16'h9999, "R7 new value");
        bus_write(8'h61, 16'h0001);
        bus_read(8'h60, 16'h0000, "R7 later ack clears");

        // R8 interrupt
        pulse_in(0, 16'h0101, 1'b0);
        chk("R8 polled event no irq", 32'(irq_o), 0);
        pulse_in(3, 16'h0303, 1'b0);
        chk("R8 interrupt event irq", 32'(irq_o), 1);
        bus_write(8'h62, 16'h0000);
        chk("R8 mode polled masks irq", 32'(irq_o), 0);
        bus_write(8'h62, 16'h0008);
        chk("R8 mode back raises irq", 32'(irq_o), 1);
        bus_write(8'h61, 16'h0008);
        chk("R8 ack drops irq", 32'(irq_o), 0);
        bus_read(8'h60, 16'h0001, "R8 polled flag still pending");

        // R9 bus drive
        bus_addr = 8'h00; bus_oe = 1'b1;
        #1;
        chk("R9 miss no drive", 32'(bus_rdata_drive), 0);
        chk("R9 miss rdata zero", 32'(bus_rdata), 0);
        bus_addr = 8'h40; bus_oe = 1'b0;
        #1;
        chk("R9 oe low no drive", 32'(bus_rdata_drive), 0);
        chk("R9 oe low rdata zero", 32'(bus_rdata), 0);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule